// File: doc/BRIEF.md
# Concurrent Root Snapshot Engine

This block captures the root set of a garbage collector at one instant while the mutator runs without any pause. The roots are the live value of one mutator register and the contents of one root stack. The stack sits in a dual-ported RAM inside the block. The mutator keeps one port for its own pushes, pops and reads. The engine uses the other port to read the stack out.

A one-cycle pulse on `gcTrig` starts a run. In the trigger cycle a scan pointer is loaded with the stack-top value minus one. From the next cycle the scan pointer walks downward through the stack, one entry per cycle. The register value is copied into a shadow register in the cycle after the trigger. Roots come out on `rootData` with `rootValid` high: first every stack entry, from the top down, and then the shadow copy. The shadow root is flagged by `snapDone`. Because the scan moves at one entry per cycle, and a pop can remove at most one entry per cycle, the scan always reads an entry before the mutator can pop it and overwrite it. No copy of the stack and no interlock are needed.

Top module: `root_snapshot`

## Requirements
- R1: After reset, `rootValid` and `snapDone` are low and stay low while no trigger arrives.
- R2: When the engine is idle, a one-cycle `gcTrig` starts a snapshot. `rootValid` stays low in the cycle after the trigger, and the first root appears two cycles after the trigger.
- R3: A `gcTrig` that arrives while a snapshot is running is ignored. The run emits the same roots, and no further root or `snapDone` follows it.
- R4: The stack entries are emitted on consecutive cycles in descending address order. The first entry comes from address `stackTop-1`, using the `stackTop` value in the trigger cycle, and the last comes from address 0. A full stack (`stackTop` = 2^AW) is emitted completely.
- R5: The shadow root equals the `mutRegVal` value present during the cycle after the trigger. A new register value that latches at the end of that cycle does not change it.
- R6: The shadow root follows the last stack root in the very next cycle. `snapDone` is high in exactly that cycle and for one cycle only.
- R7: With `stackTop` = 0, the only root emitted is the shadow root, two cycles after the trigger, together with `snapDone`.
- R8: Zero-valued entries are emitted with `rootValid` high, so every run emits exactly `stackTop+1` roots.
- R9: Mutator port: a write stores `mutWrData` at `mutAddr`. `mutRdData` returns the word at `mutAddr` one cycle later, and on a write it returns the old word.
- R10: Mutator writes to the address being scanned in the same cycle, or to addresses already scanned, do not alter the emitted snapshot. The scan returns the value stored before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gcTrig | input | 1 | One-cycle collection start pulse |
| stackTop | input | AW+1 | Mutator stack-top: number of entries, addresses the slot above the top |
| mutRegVal | input | DW | Current value of the mutator root register |
| mutWrEn | input | 1 | Mutator stack-port write enable |
| mutAddr | input | AW | Mutator stack-port address |
| mutWrData | input | DW | Mutator stack-port write data |
| mutRdData | output | DW | Mutator stack-port read data, one cycle latency, read-first |
| rootValid | output | 1 | A root is present on `rootData` |
| rootData | output | DW | Emitted root value |
| snapDone | output | 1 | High with the final (shadow) root of a run |

## Verification
The bench builds the block with DW = 16 and AW = 4, so the stack holds 16 entries. With that depth the bench can fill the stack completely and check the full-depth scan, where `stackTop` has its top bit set and the scan pointer starts at 15. The same depth keeps the empty-stack run, a mid-depth run containing a null entry, and a run in which the mutator overwrites every entry as it is scanned short enough to trace cycle by cycle. A retrigger in the middle of a run and a register write that latches at the end of the capture cycle are also covered.

// File: rtl/rsnap_pkg.sv
package rsnap_pkg;

  typedef enum logic [1:0] {
    SNAP_IDLE  = 2'd0,
    SNAP_STACK = 2'd1,
    SNAP_REG   = 2'd2,
    SNAP_DONE  = 2'd3
  } snapState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadScan;   // trigger accepted: load scan pointer
    logic stepScan;   // read stack at scan pointer, then step down
    logic capShadow;  // copy mutator register into shadow
    logic emitShadow; // queue shadow value for output
  } snapCmd_t;

endpackage

// File: rtl/rsnap_tdp_ram.sv
module rsnap_tdp_ram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          aWe,
  input  logic [AW-1:0] aAddr,
  input  logic [DW-1:0] aWData,
  output logic [DW-1:0] aRData,
  input  logic          bEn,
  input  logic [AW-1:0] bAddr,
  output logic [DW-1:0] bRData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // port A: mutator, read-first
  always_ff @(posedge clk) begin
    if (aWe) mem[aAddr] <= aWData;
    aRData <= mem[aAddr];
  end

  // port B: scan, read only
  always_ff @(posedge clk) begin
    if (bEn) bRData <= mem[bAddr];
  end

endmodule

// File: rtl/rsnap_ctrl.sv
module rsnap_ctrl
  import rsnap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     gcTrig,
  input  logic     topEmpty,
  input  logic     scanLast,
  output snapCmd_t cmd,
  output logic     snapDone
);
  snapState_t state, stateNxt;
  logic       firstCyc;
  logic       accept;

  assign accept = (state == SNAP_IDLE) && gcTrig;

  always_comb begin
    stateNxt = state;
    unique case (state)
      SNAP_IDLE:  if (accept) stateNxt = topEmpty ? SNAP_REG : SNAP_STACK;
      SNAP_STACK: if (scanLast) stateNxt = SNAP_REG;
      SNAP_REG:   stateNxt = SNAP_DONE;
      SNAP_DONE:  stateNxt = SNAP_IDLE;
      default:    stateNxt = SNAP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SNAP_IDLE;
      firstCyc <= 1'b0;
    end else begin
      state    <= stateNxt;
      firstCyc <= accept;
    end
  end

  always_comb begin
    cmd.loadScan   = accept;
    cmd.stepScan   = (state == SNAP_STACK);
    cmd.capShadow  = firstCyc;
    cmd.emitShadow = (state == SNAP_REG);
  end

  assign snapDone = (state == SNAP_DONE);

  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != SNAP_IDLE && gcTrig) |=> !firstCyc); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    snapDone |=> !snapDone); // R6

  AST_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    firstCyc |-> (state == SNAP_STACK || state == SNAP_REG)); // R5

endmodule

// File: rtl/rsnap_dpath.sv
module rsnap_dpath
  import rsnap_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  snapCmd_t      cmd,
  input  logic [AW:0]   stackTop,
  input  logic [DW-1:0] mutRegVal,
  input  logic [DW-1:0] scanRData,
  output logic          scanRdEn,
  output logic [AW-1:0] scanAddr,
  output logic          topEmpty,
  output logic          scanLast,
  output logic          rootValid,
  output logic [DW-1:0] rootData
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] scanPtr;
  logic [DW-1:0] shadowReg;
  logic          stackPend;
  logic          regPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanPtr <= '0;
    end else if (cmd.loadScan) begin
      scanPtr <= stackTop[AW-1:0] - AW'(1);
    end else if (cmd.stepScan) begin
      scanPtr <= scanPtr - AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowReg <= '0;
      stackPend <= 1'b0;
      regPend   <= 1'b0;
    end else begin
      if (cmd.capShadow) shadowReg <= mutRegVal;
      stackPend <= cmd.stepScan;
      regPend   <= cmd.emitShadow;
    end
  end

  assign topEmpty  = (stackTop == '0);
  assign scanLast  = (scanPtr == '0);
  assign scanRdEn  = cmd.stepScan;
  assign scanAddr  = scanPtr;
  assign rootValid = stackPend | regPend;
  assign rootData  = regPend ? shadowReg : scanRData;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(stackPend && regPend)); // R6

  AST_REG_LAST: assert property (@(posedge clk) disable iff (!rstN)
    regPend |=> !stackPend); // R6

  AST_TOP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadScan |-> (int'(stackTop) <= DEPTH)); // R4

endmodule

// File: rtl/root_snapshot.sv
module root_snapshot
  import rsnap_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          gcTrig,
  input  logic [AW:0]   stackTop,
  input  logic [DW-1:0] mutRegVal,
  input  logic          mutWrEn,
  input  logic [AW-1:0] mutAddr,
  input  logic [DW-1:0] mutWrData,
  output logic [DW-1:0] mutRdData,
  output logic          rootValid,
  output logic [DW-1:0] rootData,
  output logic          snapDone
);
  snapCmd_t      cmd;
  logic          topEmpty;
  logic          scanLast;
  logic          scanRdEn;
  logic [AW-1:0] scanAddr;
  logic [DW-1:0] scanRData;

  rsnap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .gcTrig   (gcTrig),
    .topEmpty (topEmpty),
    .scanLast (scanLast),
    .cmd      (cmd),
    .snapDone (snapDone)
  );

  rsnap_dpath #(.DW(DW), .AW(AW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .stackTop  (stackTop),
    .mutRegVal (mutRegVal),
    .scanRData (scanRData),
    .scanRdEn  (scanRdEn),
    .scanAddr  (scanAddr),
    .topEmpty  (topEmpty),
    .scanLast  (scanLast),
    .rootValid (rootValid),
    .rootData  (rootData)
  );

  rsnap_tdp_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk    (clk),
    .aWe    (mutWrEn),
    .aAddr  (mutAddr),
    .aWData (mutWrData),
    .aRData (mutRdData),
    .bEn    (scanRdEn),
    .bAddr  (scanAddr),
    .bRData (scanRData)
  );

  AST_DONE_WITH_ROOT: assert property (@(posedge clk) disable iff (!rstN)
    snapDone |-> rootValid); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!rootValid && !snapDone)); // R1

endmodule

// File: tb/root_snapshot_bench.sv
`timescale 1ns/1ps
module root_snapshot_bench;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          gcTrig;
  logic [AW:0]   stackTop;
  logic [DW-1:0] mutRegVal;
  logic          mutWrEn;
  logic [AW-1:0] mutAddr;
  logic [DW-1:0] mutWrData;
  logic [DW-1:0] mutRdData;
  logic          rootValid;
  logic [DW-1:0] rootData;
  logic          snapDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] pend  [DEPTH];
  bit            pendV [DEPTH];

  always #2.5 clk = ~clk;

  root_snapshot #(.DW(DW), .AW(AW)) u_root_snapshot (
    .clk(clk), .rstN(rstN), .gcTrig(gcTrig), .stackTop(stackTop),
    .mutRegVal(mutRegVal), .mutWrEn(mutWrEn), .mutAddr(mutAddr),
    .mutWrData(mutWrData), .mutRdData(mutRdData), .rootValid(rootValid),
    .rootData(rootData), .snapDone(snapDone)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(!rootValid && !snapDone, req, {rootValid, snapDone}, 0);
    end
  endtask

  // R9 fill through mutator port
  task automatic fillStack();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      mutWrEn = 1'b1; mutAddr = AW'(a);
      mutWrData = (a == 3) ? '0 : DW'(16'h1000 + a * 17);
      model[a] = mutWrData;
    end
    @(negedge clk);
    mutWrEn = 1'b0;
  endtask

  // R9 readback with one-cycle latency
  task automatic readBack(input int n);
    for (int a = 0; a < n; a++) begin
      @(negedge clk);
      mutAddr = AW'(a);
      @(negedge clk);
      check(mutRdData == model[a], "R9 readback", mutRdData, model[a]);
    end
  endtask

  // one snapshot run; called at a negedge
  task automatic snapRun(input int depth, input logic [DW-1:0] regVal,
                         input logic [DW-1:0] regNext, input bit collide,
                         input int retrigAt, input string tag);
    logic [DW-1:0] exp;
    for (int a = 0; a < DEPTH; a++) pendV[a] = 0;
    @(negedge clk);
    stackTop = (AW+1)'(depth);
    mutRegVal = regVal;
    gcTrig = 1'b1;
    @(negedge clk);                       // cycle after trigger
    gcTrig = 1'b0;
    check(!rootValid, {tag, " R2 no root in capture cycle"}, rootValid, 0);
    if (collide && depth > 0) begin       // R10 write the address scanned now
      mutWrEn = 1'b1; mutAddr = AW'(depth - 1);
      mutWrData = ~model[depth-1];
      pend[depth-1] = mutWrData; pendV[depth-1] = 1;
    end
    @(posedge clk);
    mutRegVal <= regNext;                 // R5 new value latches at end of capture cycle
    for (int i = 0; i <= depth; i++) begin
      @(negedge clk);
      mutWrEn = 1'b0;
      gcTrig = (i == retrigAt);
      exp = (i < depth) ? model[depth-1-i] : regVal;
      check(rootValid, {tag, (i < depth) ? " R4 stack root valid" : " R6 shadow valid"}, rootValid, 1);
      check(rootData == exp, {tag, (i < depth) ? " R4/R8 stack order R10" : " R5 shadow value"}, rootData, exp);
      check(snapDone == (i == depth), {tag, " R6 done timing"}, snapDone, (i == depth));
      if (collide && (depth - 2 - i) >= 0) begin
        mutWrEn = 1'b1; mutAddr = AW'(depth - 2 - i);
        mutWrData = ~model[depth-2-i] ^ DW'(i);
        pend[depth-2-i] = mutWrData; pendV[depth-2-i] = 1;
      end
    end
    @(negedge clk);
    gcTrig = 1'b0; mutWrEn = 1'b0;
    check(!rootValid && !snapDone, {tag, " R6 run ends after shadow"}, {rootValid, snapDone}, 0);
    for (int a = 0; a < DEPTH; a++) if (pendV[a]) model[a] = pend[a];
    quiet(4, {tag, " R3 no extra run"});
  endtask

  task automatic testReset();
    rstN = 1'b0; gcTrig = 1'b0; stackTop = '0; mutRegVal = '0;
    mutWrEn = 1'b0; mutAddr = '0; mutWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(!rootValid && !snapDone, "R1 reset outputs", {rootValid, snapDone}, 0);
    quiet(3, "R1 idle quiet");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    fillStack();
    readBack(DEPTH);
    snapRun(5, 16'hABCD, 16'h5555, 0, -1, "mid");        // includes null at addr 3 (R8)
    snapRun(0, 16'h0F0F, 16'h1111, 0, -1, "empty R7");
    snapRun(DEPTH, 16'h0000, 16'hFFFF, 0, 1, "full");     // R3 retrigger mid-run, null shadow R8
    snapRun(6, 16'h2468, 16'h1357, 1, 6, "collide");      // R10, R3 retrigger in done cycle
    readBack(6);                                          // R9 writes landed
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule